// File: doc/BRIEF.md
# Packed Instruction Word Slot Sequencer

This block sits between instruction memory and an execute stage. It takes an 18-bit instruction word that packs four opcode slots, keeps it in a one-word buffer and presents one 5-bit opcode per clock from that buffer, in slot order. Each opcode comes with a valid strobe and the index of the slot it came from.

The first three slots are full 5-bit opcodes. The last slot is only 3 bits wide, so it can reach only part of the opcode space. The block widens it to 5 bits before issue. A word is finished after its last slot, or earlier when a slot holds an opcode marked as a control transfer. The block then raises a fetch request and issues nothing until memory supplies the next word.

A designated micro-loop opcode makes the buffered word act as a small loop cache. While a loaded iteration count is nonzero, that opcode sends the sequencer back to slot 0 of the same word and decrements the count. No memory fetch takes place.

Top module: `slot_seq`

## Requirements
- R1: Slot 0 is taken from word bits 17:13, slot 1 from bits 12:8 and slot 2 from bits 7:3. Each is issued unchanged as a 5-bit opcode.
- R2: Slot 3 is word bits 2:0. It is issued as the 5-bit opcode {bits 2:0, 2'b00}, so the two low opcode bits are always zero for slot 3.
- R3: While rst_ni is low, and in the first cycle after it rises, fetch_req_o is 1 and op_valid_o is 0. The loop count resets to 0.
- R4: A word is accepted at a clock edge where fetch_req_o and word_valid_i are both high. In the next cycle op_valid_o is 1 with slot_o = 0. While fetch_req_o is low, word_valid_i and word_i have no effect on what is issued.
- R5: Without a loop restart or a control transfer, slots issue on consecutive cycles in the order 0, 1, 2, 3, one opcode per cycle.
- R6: In the cycle after slot 3 issues without a loop restart, fetch_req_o is 1 and op_valid_o is 0. Both stay that way until a word is accepted.
- R7: An issued opcode whose bit is set in CTRL_MASK (default: opcodes 0x00 to 0x03) ends the word. In the next cycle fetch_req_o is 1 and the remaining slots are not issued.
- R8: If the opcode OP_LOOP (default 0x1C) issues while the loop count is nonzero, the next cycle issues slot 0 of the same word and the count drops by one. If the count is zero, OP_LOOP behaves like an ordinary opcode.
- R9: loop_load_i high at a clock edge loads loop_cnt_i into the loop count. A load takes priority over the decrement of a loop restart in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 18 | Instruction word from memory |
| word_valid_i | input | 1 | word_i is present; taken only while fetch_req_o is high |
| fetch_req_o | output | 1 | Buffer is empty; a new word is wanted |
| loop_load_i | input | 1 | Load loop_cnt_i into the loop count |
| loop_cnt_i | input | CNT_W | Loop iteration count value |
| op_o | output | 5 | Issued opcode |
| op_valid_o | output | 1 | op_o and slot_o are valid this cycle |
| slot_o | output | 2 | Slot index of the issued opcode |

## Verification
The bench builds the block with CNT_W = 3 and the default opcode choices: OP_LOOP = 0x1C and control transfers at opcodes 0x00 to 0x03. With these values a 3-bit slot value of 3'b111 widens to the loop opcode and 3'b000 widens to a control transfer. This lets the bench cover loop restarts from both a full slot and the short slot, and an early word end from the short slot. The small count width keeps each loop sequence short enough to list in full, including the case where a count load in the same cycle as a restart overrides the decrement.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  localparam int WORD_W  = 18;
  localparam int OP_W    = 5;
  localparam int SHORT_W = 3;
  localparam int SLOTS   = 4;
  localparam int SLOT_IW = $clog2(SLOTS);

  typedef logic [OP_W-1:0]    op_t;
  typedef logic [SLOT_IW-1:0] slot_t;

  // short slot sits in the high bits of the opcode; the low bits are zero
  function automatic op_t widen_short(input logic [SHORT_W-1:0] s);
    return {s, {(OP_W-SHORT_W){1'b0}}};
  endfunction
endpackage

// File: rtl/slot_extract.sv
module slot_extract
  import slot_seq_pkg::*;
#(
  parameter int W_WORD  = WORD_W,
  parameter int W_OP    = OP_W,
  parameter int W_SHORT = SHORT_W,
  parameter int N_SLOT  = SLOTS,
  localparam int IW     = $clog2(N_SLOT)
) (
  input  logic [W_WORD-1:0] word_i,
  input  logic [IW-1:0]     sel_i,
  output logic [W_OP-1:0]   op_o
);
  logic [W_OP-1:0] slot_op [N_SLOT];

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    if (g < N_SLOT - 1) begin : g_full
      localparam int LSB = W_WORD - (g + 1) * W_OP;
      assign slot_op[g] = word_i[LSB +: W_OP];
    end else begin : g_short
      assign slot_op[g] = {word_i[W_SHORT-1:0], {(W_OP-W_SHORT){1'b0}}};
    end
  end

  assign op_o = slot_op[sel_i];
endmodule

// File: rtl/word_buf.sv
module word_buf #(
  parameter int W_WORD = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [W_WORD-1:0] word_i,
  input  logic              release_i,
  output logic [W_WORD-1:0] word_o,
  output logic              vld_o
);
  logic [W_WORD-1:0] word_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (load_i) begin
        word_q <= word_i;
        vld_q  <= 1'b1;
      end else if (release_i) begin
        vld_q  <= 1'b0;
      end
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  // held word never changes while it is being issued
  p_word_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !release_i |=> word_q == $past(word_q));

  // loads only land in an empty buffer
  p_load_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !vld_q);
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl #(
  parameter int          W_OP      = 5,
  parameter int          N_SLOT    = 4,
  parameter int          CNT_W     = 8,
  parameter logic [W_OP-1:0] OP_LOOP = 5'h1C,
  parameter logic [(1<<W_OP)-1:0] CTRL_MASK = 32'h0000_000F,
  localparam int         IW        = $clog2(N_SLOT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             issue_i,
  input  logic [W_OP-1:0]  op_i,
  input  logic             loop_load_i,
  input  logic [CNT_W-1:0] loop_cnt_i,
  output logic [IW-1:0]    slot_o,
  output logic             end_word_o
);
  localparam logic [IW-1:0] LAST = IW'(N_SLOT - 1);

  logic [IW-1:0]    slot_q, slot_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             loop_take, ctrl_hit;

  assign loop_take  = issue_i && (op_i == OP_LOOP) && (cnt_q != '0);
  assign ctrl_hit   = CTRL_MASK[op_i];
  assign end_word_o = issue_i && !loop_take && (ctrl_hit || slot_q == LAST);

  always_comb begin
    slot_d = slot_q;
    if (accept_i || loop_take)       slot_d = '0;
    else if (issue_i && !end_word_o) slot_d = slot_q + IW'(1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (loop_load_i)    cnt_d = loop_cnt_i;
    else if (loop_take) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      cnt_q  <= '0;
    end else begin
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
    end
  end

  assign slot_o = slot_q;

  p_advance_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !end_word_o && !loop_take |=> slot_q == $past(slot_q) + IW'(1));

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_take |=> slot_q == '0);

  p_cnt_dec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_take && !loop_load_i |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  p_cnt_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_load_i |=> cnt_q == $past(loop_cnt_i));
endmodule

// File: rtl/slot_seq.sv
module slot_seq
  import slot_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [OP_W-1:0] OP_LOOP = 5'h1C,
  parameter logic [(1<<OP_W)-1:0] CTRL_MASK = 32'h0000_000F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic             word_valid_i,
  output logic             fetch_req_o,
  input  logic             loop_load_i,
  input  logic [CNT_W-1:0] loop_cnt_i,
  output logic [OP_W-1:0]  op_o,
  output logic             op_valid_o,
  output logic [SLOT_IW-1:0] slot_o
);
  localparam logic [SLOT_IW-1:0] LAST = SLOT_IW'(SLOTS - 1);

  logic [WORD_W-1:0]  cur_word;
  logic               buf_vld, accept, end_word;
  logic [SLOT_IW-1:0] slot;
  op_t                op;

  assign accept = !buf_vld && word_valid_i;

  word_buf #(.W_WORD(WORD_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .word_i    (word_i),
    .release_i (end_word),
    .word_o    (cur_word),
    .vld_o     (buf_vld)
  );

  slot_extract #(
    .W_WORD (WORD_W),
    .W_OP   (OP_W),
    .W_SHORT(SHORT_W),
    .N_SLOT (SLOTS)
  ) u_ext (
    .word_i (cur_word),
    .sel_i  (slot),
    .op_o   (op)
  );

  slot_ctrl #(
    .W_OP     (OP_W),
    .N_SLOT   (SLOTS),
    .CNT_W    (CNT_W),
    .OP_LOOP  (OP_LOOP),
    .CTRL_MASK(CTRL_MASK)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .issue_i     (buf_vld),
    .op_i        (op),
    .loop_load_i (loop_load_i),
    .loop_cnt_i  (loop_cnt_i),
    .slot_o      (slot),
    .end_word_o  (end_word)
  );

  assign fetch_req_o = !buf_vld;
  assign op_valid_o  = buf_vld;
  assign op_o        = op;
  assign slot_o      = slot;

  p_short_low_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && slot_o == LAST |-> op_o[OP_W-SHORT_W-1:0] == '0);

  p_accept_slot0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && word_valid_i |=> op_valid_o && slot_o == '0);

  p_last_to_fetch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && slot_o == LAST && op_o != OP_LOOP |=> fetch_req_o && !op_valid_o);

  p_ctrl_to_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && CTRL_MASK[op_o] && op_o != OP_LOOP |=> fetch_req_o);

  p_wait_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !word_valid_i |=> fetch_req_o);
endmodule

// File: tb/tb_slot_seq.sv
module tb_slot_seq;
  localparam int CNT_W = 3;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [17:0] word_i;
  logic        word_valid_i;
  logic        fetch_req_o;
  logic        loop_load_i;
  logic [CNT_W-1:0] loop_cnt_i;
  logic [4:0]  op_o;
  logic        op_valid_o;
  logic [1:0]  slot_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  slot_seq #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .word_valid_i(word_valid_i),
    .fetch_req_o(fetch_req_o), .loop_load_i(loop_load_i), .loop_cnt_i(loop_cnt_i),
    .op_o(op_o), .op_valid_o(op_valid_o), .slot_o(slot_o)
  );

  // {s0, s1, s2, s3(3b), issued count(3b)}, loop count is zero here
  localparam logic [20:0] VEC [5] = '{
    {5'h10, 5'h11, 5'h12, 3'b101, 3'd4},
    {5'h15, 5'h02, 5'h12, 3'b110, 3'd2},
    {5'h01, 5'h13, 5'h14, 3'b101, 3'd1},
    {5'h1C, 5'h1D, 5'h0A, 3'b011, 3'd4},
    {5'h05, 5'h06, 5'h03, 3'b100, 3'd3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] mk(input logic [4:0] a, input logic [4:0] b,
                                     input logic [4:0] c, input logic [2:0] d);
    return {a, b, c, d};
  endfunction

  task automatic feed(input logic [17:0] w);
    chk(fetch_req_o === 1'b1, "R6 fetch before feed", fetch_req_o, 1);
    word_i = w;
    word_valid_i = 1'b1;
    @(negedge clk);
    word_valid_i = 1'b0;
  endtask

  task automatic expect_op(input int s, input logic [4:0] o, input string tag);
    chk(op_valid_o === 1'b1 && slot_o === 2'(s) && op_o === o, tag,
        {op_valid_o, slot_o, op_o}, {1'b1, 2'(s), o});
    @(negedge clk);
  endtask

  task automatic expect_fetch(input string tag);
    chk(fetch_req_o === 1'b1 && op_valid_o === 1'b0, tag,
        {fetch_req_o, op_valid_o}, 2'b10);
  endtask

  task automatic load_cnt(input int v);
    loop_load_i = 1'b1;
    loop_cnt_i = CNT_W'(v);
    @(negedge clk);
    loop_load_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    word_i = '0;
    word_valid_i = 1'b0;
    loop_load_i = 1'b0;
    loop_cnt_i = '0;
    repeat (2) @(negedge clk);
    expect_fetch("R3 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    expect_fetch("R3 after reset");

    // table walk: R1 slot fields, R2 short widening, R5 order, R7 early end
    for (int v = 0; v < 5; v++) begin
      logic [4:0] s0, s1, s2, ex;
      logic [2:0] s3;
      int n;
      s0 = VEC[v][20:16];
      s1 = VEC[v][15:11];
      s2 = VEC[v][10:6];
      s3 = VEC[v][5:3];
      n  = int'(VEC[v][2:0]);
      feed(mk(s0, s1, s2, s3));
      for (int k = 0; k < n; k++) begin
        ex = (k == 0) ? s0 : (k == 1) ? s1 : (k == 2) ? s2 : {s3, 2'b00};
        expect_op(k, ex, (k == 3) ? "R2 short slot" : "R1 R5 R7 slot issue");
      end
      expect_fetch("R6 R7 word end");
      @(negedge clk);
      expect_fetch("R6 hold without word");
    end

    // R4: word_valid_i ignored while a word is being issued
    feed(mk(5'h10, 5'h11, 5'h12, 3'b101));
    word_i = mk(5'h01, 5'h01, 5'h01, 3'b000);
    word_valid_i = 1'b1;
    expect_op(0, 5'h10, "R4 busy ignore");
    expect_op(1, 5'h11, "R4 busy ignore");
    word_valid_i = 1'b0;
    expect_op(2, 5'h12, "R4 busy ignore");
    expect_op(3, 5'h14, "R4 busy ignore");
    expect_fetch("R6 after ignore");

    // R8: loop in slot 2, count 2
    load_cnt(2);
    feed(mk(5'h10, 5'h11, 5'h1C, 3'b101));
    for (int r = 0; r < 3; r++) begin
      expect_op(0, 5'h10, "R8 loop slot2");
      expect_op(1, 5'h11, "R8 loop slot2");
      expect_op(2, 5'h1C, "R8 loop slot2");
    end
    expect_op(3, 5'h14, "R8 loop exhausted");
    expect_fetch("R8 fetch after loop");

    // R8: loop from the short slot (3'b111 -> 0x1C), count 1
    load_cnt(1);
    feed(mk(5'h10, 5'h11, 5'h12, 3'b111));
    for (int r = 0; r < 2; r++) begin
      expect_op(0, 5'h10, "R8 loop slot3");
      expect_op(1, 5'h11, "R8 loop slot3");
      expect_op(2, 5'h12, "R8 loop slot3");
      expect_op(3, 5'h1C, "R8 loop slot3");
    end
    expect_fetch("R8 R6 fetch after short loop");

    // R9: load during a restart overrides the decrement
    load_cnt(1);
    feed(mk(5'h1C, 5'h11, 5'h12, 3'b101));
    loop_load_i = 1'b1;
    loop_cnt_i = CNT_W'(2);
    expect_op(0, 5'h1C, "R9 load with restart");
    loop_load_i = 1'b0;
    expect_op(0, 5'h1C, "R9 override count");
    expect_op(0, 5'h1C, "R9 override count");
    expect_op(0, 5'h1C, "R9 override count");
    expect_op(1, 5'h11, "R9 count spent");
    expect_op(2, 5'h12, "R9 count spent");
    expect_op(3, 5'h14, "R9 count spent");
    expect_fetch("R9 fetch");

    // R3: asynchronous reset in the middle of a word
    feed(mk(5'h10, 5'h11, 5'h12, 3'b101));
    expect_op(0, 5'h10, "R3 pre-reset issue");
    rst_ni = 1'b0;
    #1;
    expect_fetch("R3 async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    expect_fetch("R3 after second reset");
    // loop count must be zero after reset: 0x1C acts as plain opcode
    feed(mk(5'h1C, 5'h11, 5'h12, 3'b101));
    expect_op(0, 5'h1C, "R3 R8 count cleared");
    expect_op(1, 5'h11, "R3 R8 count cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule